// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes or words between a single data port and on-board packet memory without addressing that memory directly. The host first programs a 16-bit memory pointer and a 16-bit transfer length, each as two byte-wide registers. It then reads or writes the data port repeatedly. Every data-port access moves one unit at the pointer, advances the pointer and shortens the remaining length. When the length runs out, a sticky completion flag is raised.

The pointer runs inside a receive ring whose first and last-plus-one pages are programmable. When the pointer lands exactly on the ring's end address, it jumps back to the ring's first address. A configuration bit selects 8-bit or 16-bit transfers. In 16-bit mode the memory access uses the pointer with bit 0 cleared, and the two bytes are little-endian.

Memory seen through the port has two regions. Addresses 0 to 31 hold an identity PROM, which carries the 6-byte station address with every byte stored twice. Packet RAM starts at byte 16384; its size is a parameter, and 32768 bytes is the full size. All other addresses float high. Reading the reset offset clears the completion flag and rebuilds the PROM.

Top module: `rdma_port_engine`

## Requirements
- R1: Offsets 0x08/0x09 hold the low/high byte of the memory pointer, and 0x0A/0x0B hold the low/high byte of the transfer length. Each byte is written on its own and reads back on rdata_o[7:0] with bits [15:8] zero, one cycle after the read strobe.
- R2: With configuration bit 0 clear (offset 0x0E), a data-port access at offset 0x10 moves one byte at the pointer. Read data appears on rdata_o[7:0] with bits [15:8] zero, one cycle after the strobe. A write takes wdata_i[7:0].
- R3: With configuration bit 0 set, a data-port access moves 16 bits at the pointer with bit 0 forced to zero. Bits [7:0] map to the even byte and bits [15:8] to the odd byte.
- R4: After an access made while the length is nonzero, the pointer grows by the transfer size (1 or 2). If the result equals the end page (offset 0x02) times 256, the pointer is reloaded with the first page (offset 0x01) times 256. Only exact equality wraps.
- R5: If the length is at most the transfer size, it becomes zero and the completion flag is set. The flag is status bit 6 at offset 0x07 and is also driven on done_o. Otherwise the length drops by the transfer size.
- R6: A data-port access made while the length is zero still moves data. It leaves the pointer, the length and the completion flag unchanged.
- R7: Bytes RAM_BASE to RAM_BASE+RAM_BYTES-1 (default 16384 and 4096) are read/write packet RAM.
- R8: PROM byte a (a < 32) holds station-address byte a/2 for a/2 < 6, where byte 0 is mac_i[7:0], and zero otherwise. It is writable through the data port.
- R9: Data-port writes outside the PROM and RAM change nothing. Reads there return 0x00FF in byte mode and 0xFFFF in word mode.
- R10: Writing offset 0x07 with bit 6 set clears the completion flag. A write with bit 6 clear leaves the flag as it is.
- R11: A read of offset 0x1F returns zero and clears the completion flag. It restores the PROM contents of R8 within two cycles and leaves the pointer and the length unchanged.
- R12: After reset the pointer, length, ring pages and configuration read as zero, and the completion flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mac_i | input | 48 | Station address loaded into the PROM, byte 0 in bits [7:0] |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
The hardest state to reach is the ring wrap under 16-bit transfers from an odd pointer. There the forced-even memory address and the raw pointer disagree, so an advance can step over the end address without wrapping. Directed cases place the pointer just below a narrow ring in both parities. Seeded random traffic then reprograms narrow rings, short lengths and the transfer width between bursts, so wraps and completions fall in both modes. Zero-length accesses are aimed at RAM, and the pointer is read back afterwards, to show that nothing advanced.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [4:0] OFF_START   = 5'h01;
  localparam logic [4:0] OFF_STOP    = 5'h02;
  localparam logic [4:0] OFF_STAT    = 5'h07;
  localparam logic [4:0] OFF_ADDR_LO = 5'h08;
  localparam logic [4:0] OFF_ADDR_HI = 5'h09;
  localparam logic [4:0] OFF_CNT_LO  = 5'h0A;
  localparam logic [4:0] OFF_CNT_HI  = 5'h0B;
  localparam logic [4:0] OFF_CFG     = 5'h0E;
  localparam logic [4:0] OFF_DATA    = 5'h10;
  localparam logic [4:0] OFF_SRST    = 5'h1F;
  localparam int         DONE_BIT    = 6;

  typedef enum logic [1:0] {RGN_PROM, RGN_RAM, RGN_NONE} region_e;
  typedef enum logic [1:0] {SRC_REG, SRC_PROM, SRC_RAM, SRC_ONES} rd_src_e;
endpackage

// File: rtl/rdma_region_dec.sv
module rdma_region_dec
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PROM_BYTES = 32,
  parameter int RAM_BASE   = 16384,
  parameter int RAM_BYTES  = 4096,
  localparam int PROM_IDX_W = $clog2(PROM_BYTES / 2),
  localparam int RAM_IDX_W  = $clog2(RAM_BYTES / 2)
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output region_e               region_o,
  output logic [PROM_IDX_W-1:0] prom_idx_o,
  output logic [RAM_IDX_W-1:0]  ram_idx_o
);
  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    if (a32 < 32'(PROM_BYTES))
      region_o = RGN_PROM;
    else if (a32 >= 32'(RAM_BASE) && a32 < 32'(RAM_BASE + RAM_BYTES))
      region_o = RGN_RAM;
    else
      region_o = RGN_NONE;
  end

  assign prom_idx_o = PROM_IDX_W'(addr_i >> 1);
  assign ram_idx_o  = RAM_IDX_W'((addr_i - ADDR_W'(RAM_BASE)) >> 1);
endmodule

// File: rtl/rdma_prom.sv
module rdma_prom #(
  parameter int BYTES     = 32,
  parameter int MAC_BYTES = 6,
  localparam int IDX_W    = $clog2(BYTES / 2)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reload_i,
  input  logic [8*MAC_BYTES-1:0] mac_i,
  input  logic                   we_i,
  input  logic [1:0]             be_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [15:0]            wdata_i,
  input  logic                   re_i,
  output logic [15:0]            rdata_o
);
  logic [7:0] byte_q [BYTES];
  logic [7:0] fill_w [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam int SRC  = b / 2;
    localparam int LANE = b % 2;
    // every station-address byte lands in two neighbouring cells
    if (SRC < MAC_BYTES) begin : g_mac
      assign fill_w[b] = mac_i[8*SRC +: 8];
    end else begin : g_zero
      assign fill_w[b] = 8'h00;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        byte_q[b] <= 8'h00;
      else if (reload_i)
        byte_q[b] <= fill_w[b];
      else if (we_i && be_i[LANE] && idx_i == IDX_W'(SRC))
        byte_q[b] <= wdata_i[8*LANE +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 16'h0000;
    else if (re_i) rdata_o <= {byte_q[{idx_i, 1'b1}], byte_q[{idx_i, 1'b0}]};
  end
endmodule

// File: rtl/rdma_ram.sv
module rdma_ram #(
  parameter int WORDS  = 2048,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [1:0]       be_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      wdata_i,
  input  logic             re_i,
  output logic [15:0]      rdata_o
);
  logic [15:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i && be_i[0]) mem_q[idx_i][7:0]  <= wdata_i[7:0];
    if (we_i && be_i[1]) mem_q[idx_i][15:8] <= wdata_i[15:8];
    if (re_i)            rdata_o            <= mem_q[idx_i];
  end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_off_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        data_acc_i,
  input  logic        srst_i,
  output logic [15:0] ptr_o,
  output logic [15:0] len_o,
  output logic [7:0]  first_pg_o,
  output logic [7:0]  end_pg_o,
  output logic        word_mode_o,
  output logic        done_o
);
  logic [15:0] step, sum, ptr_nxt;
  logic        last;

  always_comb begin
    step    = word_mode_o ? 16'd2 : 16'd1;
    sum     = ptr_o + step;
    ptr_nxt = (sum == {end_pg_o, 8'h00}) ? {first_pg_o, 8'h00} : sum;
    last    = (len_o <= step);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o       <= '0;
      len_o       <= '0;
      first_pg_o  <= '0;
      end_pg_o    <= '0;
      word_mode_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      if (srst_i) done_o <= 1'b0;
      if (reg_we_i) begin
        unique case (reg_off_i)
          OFF_START:   first_pg_o  <= reg_wdata_i;
          OFF_STOP:    end_pg_o    <= reg_wdata_i;
          OFF_ADDR_LO: ptr_o[7:0]  <= reg_wdata_i;
          OFF_ADDR_HI: ptr_o[15:8] <= reg_wdata_i;
          OFF_CNT_LO:  len_o[7:0]  <= reg_wdata_i;
          OFF_CNT_HI:  len_o[15:8] <= reg_wdata_i;
          OFF_CFG:     word_mode_o <= reg_wdata_i[0];
          OFF_STAT:    if (reg_wdata_i[DONE_BIT]) done_o <= 1'b0;
          default: ;
        endcase
      end
      // an empty length freezes pointer, length and flag
      if (data_acc_i && len_o != 16'd0) begin
        ptr_o <= ptr_nxt;
        if (last) begin
          len_o  <= 16'd0;
          done_o <= 1'b1;
        end else begin
          len_o <= len_o - step;
        end
      end
    end
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int RAM_BASE  = 16384,
  parameter int RAM_BYTES = 4096,
  parameter int MAC_BYTES = 6,
  parameter int PROM_BYTES = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [8*MAC_BYTES-1:0] mac_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [4:0]             addr_i,
  input  logic [15:0]            wdata_i,
  output logic [15:0]            rdata_o,
  output logic                   done_o
);
  localparam int RAM_WORDS  = RAM_BYTES / 2;
  localparam int RAM_IDX_W  = $clog2(RAM_WORDS);
  localparam int PROM_IDX_W = $clog2(PROM_BYTES / 2);

  logic [15:0] ptr_q, len_q, acc_addr, prom_rd, ram_rd, mem_word, wdat;
  logic [7:0]  first_pg, end_pg, reg_val, reg_val_q;
  logic        word_mode, data_acc, reg_we, srst, rd_strobe, reload_q;
  logic        lane_q, word_q;
  logic [1:0]  wbe;
  region_e     region;
  rd_src_e     src_d, src_q;
  logic [PROM_IDX_W-1:0] prom_idx;
  logic [RAM_IDX_W-1:0]  ram_idx;

  assign rd_strobe = req_i && !we_i;
  assign data_acc  = req_i && (addr_i == OFF_DATA);
  assign reg_we    = req_i && we_i && (addr_i != OFF_DATA);
  assign srst      = rd_strobe && (addr_i == OFF_SRST);

  rdma_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we),
    .reg_off_i   (addr_i),
    .reg_wdata_i (wdata_i[7:0]),
    .data_acc_i  (data_acc),
    .srst_i      (srst),
    .ptr_o       (ptr_q),
    .len_o       (len_q),
    .first_pg_o  (first_pg),
    .end_pg_o    (end_pg),
    .word_mode_o (word_mode),
    .done_o      (done_o)
  );

  assign acc_addr = word_mode ? {ptr_q[15:1], 1'b0} : ptr_q;
  assign wbe      = word_mode ? 2'b11 : (acc_addr[0] ? 2'b10 : 2'b01);
  assign wdat     = word_mode ? wdata_i : {wdata_i[7:0], wdata_i[7:0]};

  rdma_region_dec #(
    .ADDR_W     (16),
    .PROM_BYTES (PROM_BYTES),
    .RAM_BASE   (RAM_BASE),
    .RAM_BYTES  (RAM_BYTES)
  ) u_dec (
    .addr_i     (acc_addr),
    .region_o   (region),
    .prom_idx_o (prom_idx),
    .ram_idx_o  (ram_idx)
  );

  rdma_prom #(
    .BYTES     (PROM_BYTES),
    .MAC_BYTES (MAC_BYTES)
  ) u_prom (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload_q),
    .mac_i    (mac_i),
    .we_i     (data_acc && we_i && region == RGN_PROM),
    .be_i     (wbe),
    .idx_i    (prom_idx),
    .wdata_i  (wdat),
    .re_i     (data_acc && !we_i && region == RGN_PROM),
    .rdata_o  (prom_rd)
  );

  rdma_ram #(
    .WORDS (RAM_WORDS)
  ) u_ram (
    .clk_i   (clk_i),
    .we_i    (data_acc && we_i && region == RGN_RAM),
    .be_i    (wbe),
    .idx_i   (ram_idx),
    .wdata_i (wdat),
    .re_i    (data_acc && !we_i && region == RGN_RAM),
    .rdata_o (ram_rd)
  );

  always_comb begin
    unique case (addr_i)
      OFF_START:   reg_val = first_pg;
      OFF_STOP:    reg_val = end_pg;
      OFF_STAT:    reg_val = 8'(done_o) << DONE_BIT;
      OFF_ADDR_LO: reg_val = ptr_q[7:0];
      OFF_ADDR_HI: reg_val = ptr_q[15:8];
      OFF_CNT_LO:  reg_val = len_q[7:0];
      OFF_CNT_HI:  reg_val = len_q[15:8];
      OFF_CFG:     reg_val = {7'd0, word_mode};
      default:     reg_val = 8'h00;
    endcase
    if (!data_acc)               src_d = SRC_REG;
    else if (region == RGN_PROM) src_d = SRC_PROM;
    else if (region == RGN_RAM)  src_d = SRC_RAM;
    else                         src_d = SRC_ONES;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q  <= 1'b1;
      src_q     <= SRC_REG;
      reg_val_q <= 8'h00;
      lane_q    <= 1'b0;
      word_q    <= 1'b0;
    end else begin
      reload_q <= srst;
      if (rd_strobe) begin
        src_q     <= src_d;
        reg_val_q <= reg_val;
        lane_q    <= acc_addr[0];
        word_q    <= word_mode;
      end
    end
  end

  assign mem_word = (src_q == SRC_PROM) ? prom_rd : ram_rd;

  always_comb begin
    unique case (src_q)
      SRC_REG:  rdata_o = {8'h00, reg_val_q};
      SRC_ONES: rdata_o = word_q ? 16'hFFFF : 16'h00FF;
      default:  rdata_o = word_q ? mem_word
                                 : {8'h00, lane_q ? mem_word[15:8] : mem_word[7:0]};
    endcase
  end
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk
  import rdma_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [4:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] ptr_q,
  input logic [15:0] len_q,
  input logic [7:0]  first_pg,
  input logic [7:0]  end_pg,
  input logic        word_mode,
  input logic        done_o
);
  logic        acc;
  logic        clr;
  logic [15:0] step;
  assign acc  = req_i && addr_i == OFF_DATA;
  assign clr  = req_i && we_i && addr_i == OFF_STAT && wdata_i[DONE_BIT];
  assign step = word_mode ? 16'd2 : 16'd1;

  assert_empty_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && len_q == 16'd0 |=> $stable(ptr_q) && len_q == 16'd0);

  assert_len_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && len_q > step |=> len_q == $past(len_q) - $past(step) && $stable(done_o));

  assert_done_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && len_q != 16'd0 && len_q <= step |=> len_q == 16'd0 && done_o);

  assert_never_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && len_q != 16'd0 && first_pg != end_pg |=> ptr_q != {end_pg, 8'h00});

  assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !done_o);
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .ptr_q     (ptr_q),
  .len_q     (len_q),
  .first_pg  (first_pg),
  .end_pg    (end_pg),
  .word_mode (word_mode),
  .done_o    (done_o)
);

// File: tb/rdma_port_engine_tb.sv
`timescale 1ns/1ps
module rdma_port_engine_tb;
  localparam int RAM_BASE  = 16384;
  localparam int RAM_BYTES = 4096;
  localparam logic [47:0] MAC = 48'hA1B2C3D4E5F6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done;

  int n_chk = 0, n_fail = 0;

  logic [7:0]  m_ram [RAM_BYTES];
  logic [7:0]  m_prom [32];
  logic [15:0] m_ptr = '0, m_len = '0;
  logic [7:0]  m_first = '0, m_end = '0;
  logic        m_word = 1'b0, m_done = 1'b0;

  always #10 clk = ~clk;

  rdma_port_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mac_i(MAC), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    if (a < 32) return m_prom[a];
    if (a >= RAM_BASE && a < RAM_BASE + RAM_BYTES) return m_ram[a - RAM_BASE];
    return 8'hFF;
  endfunction

  task automatic mset(input int a, input logic [7:0] d);
    if (a < 32) m_prom[a] = d;
    else if (a >= RAM_BASE && a < RAM_BASE + RAM_BYTES) m_ram[a - RAM_BASE] = d;
  endtask

  function automatic logic [15:0] mread();
    int ea = m_word ? int'(m_ptr & 16'hFFFE) : int'(m_ptr);
    return m_word ? {mbyte(ea + 1), mbyte(ea)} : {8'h00, mbyte(ea)};
  endfunction

  task automatic mwrite(input logic [15:0] d);
    int ea = m_word ? int'(m_ptr & 16'hFFFE) : int'(m_ptr);
    if (m_word) begin mset(ea, d[7:0]); mset(ea + 1, d[15:8]); end
    else mset(ea, d[7:0]);
  endtask

  task automatic madv();
    logic [15:0] st = m_word ? 16'd2 : 16'd1;
    logic [15:0] nx;
    if (m_len != 0) begin
      nx = m_ptr + st;
      m_ptr = (nx == {m_end, 8'h00}) ? {m_first, 8'h00} : nx;
      if (m_len <= st) begin m_len = 0; m_done = 1'b1; end
      else m_len = m_len - st;
    end
  endtask

  task automatic prom_fill();
    for (int i = 0; i < 32; i++) m_prom[i] = (i / 2 < 6) ? MAC[8*(i/2) +: 8] : 8'h00;
  endtask

  task automatic bus(input logic w, input logic [4:0] off, input logic [15:0] d,
                     output logic [15:0] q);
    @(negedge clk);
    req = 1'b1; we = w; addr = off; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    q = rdata;
  endtask

  task automatic setreg(input logic [4:0] off, input logic [7:0] v);
    logic [15:0] q;
    bus(1'b1, off, {8'h00, v}, q);
  endtask

  task automatic set_ptr(input logic [15:0] v);
    setreg(5'h08, v[7:0]); setreg(5'h09, v[15:8]); m_ptr = v;
  endtask
  task automatic set_len(input logic [15:0] v);
    setreg(5'h0A, v[7:0]); setreg(5'h0B, v[15:8]); m_len = v;
  endtask
  task automatic set_mode(input logic w);
    setreg(5'h0E, {7'd0, w}); m_word = w;
  endtask
  task automatic set_ring(input logic [7:0] s, input logic [7:0] e);
    setreg(5'h01, s); setreg(5'h02, e); m_first = s; m_end = e;
  endtask

  task automatic regs_chk(input string tag);
    logic [15:0] q;
    bus(1'b0, 5'h08, 0, q); chk({tag, " ptr lo R1"}, q, {8'h00, m_ptr[7:0]});
    bus(1'b0, 5'h09, 0, q); chk({tag, " ptr hi R1"}, q, {8'h00, m_ptr[15:8]});
    bus(1'b0, 5'h0A, 0, q); chk({tag, " len lo R1"}, q, {8'h00, m_len[7:0]});
    bus(1'b0, 5'h0B, 0, q); chk({tag, " len hi R1"}, q, {8'h00, m_len[15:8]});
    chk({tag, " done_o"}, {15'd0, done}, {15'd0, m_done});
  endtask

  task automatic dread(input string tag);
    logic [15:0] q, e;
    e = mread();
    bus(1'b0, 5'h10, 0, q);
    chk(tag, q, e);
    madv();
  endtask

  task automatic dwrite(input logic [15:0] d);
    logic [15:0] q;
    mwrite(d);
    bus(1'b1, 5'h10, d, q);
    madv();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] q;
    void'($urandom(32'd4711));
    prom_fill();
    for (int i = 0; i < RAM_BYTES; i++) m_ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state
    bus(1'b0, 5'h01, 0, q); chk("R12 first page", q, 16'h0000);
    bus(1'b0, 5'h02, 0, q); chk("R12 end page", q, 16'h0000);
    bus(1'b0, 5'h0E, 0, q); chk("R12 config", q, 16'h0000);
    bus(1'b0, 5'h07, 0, q); chk("R12 status", q, 16'h0000);
    regs_chk("R12");

    // R8: PROM doubled bytes, byte mode
    set_ptr(16'h0000); set_len(16'd100);
    for (int i = 0; i < 32; i++) dread("R8 prom byte");
    regs_chk("R8");

    // R3: word read from odd pointer uses even address
    set_mode(1'b1); set_ptr(16'h0003);
    dread("R3 word prom");
    regs_chk("R3 R4");

    // R7: fill RAM in word mode with a full ring wrap at the end
    set_ring(8'h40, 8'h50); set_ptr(16'h4000); set_len(16'(RAM_BYTES));
    for (int i = 0; i < RAM_BYTES / 2; i++) dwrite(16'(i * 16'h03B1 + 16'h0007));
    regs_chk("R4 R5 fill wrap");
    bus(1'b0, 5'h07, 0, q); chk("R5 status bit6", q, 16'h0040);
    set_len(16'd8);
    for (int i = 0; i < 4; i++) dread("R7 ram word");

    // R10: clear semantics
    setreg(5'h07, 8'h00);
    bus(1'b0, 5'h07, 0, q); chk("R10 write 0 keeps flag", q, 16'h0040);
    setreg(5'h07, 8'h40); m_done = 1'b0;
    bus(1'b0, 5'h07, 0, q); chk("R10 cleared", q, 16'h0000);
    chk("R10 done_o", {15'd0, done}, 16'h0000);

    // R6: zero length still transfers, no advance
    set_len(16'd0); set_ptr(16'h4010);
    dwrite(16'hBEEF);
    regs_chk("R6 after write");
    dread("R6 read at zero length");
    regs_chk("R6 after read");

    // R2: byte mode lanes, completion on last byte
    set_mode(1'b0); set_ptr(16'h4011); set_len(16'd3);
    dread("R2 high lane");
    dwrite(16'hAA5A);
    dread("R2 byte");
    regs_chk("R2 R5 last byte");
    setreg(5'h07, 8'h40); m_done = 1'b0;

    // R5: word access with length 1
    set_mode(1'b1); set_ptr(16'h4020); set_len(16'd1);
    dread("R5 short word");
    regs_chk("R5 len 1 word");
    setreg(5'h07, 8'h40); m_done = 1'b0;

    // R4: narrow ring, even and odd pointer in word mode
    set_ring(8'h41, 8'h43); set_ptr(16'h42FE); set_len(16'd10);
    dread("R4 even wrap");
    regs_chk("R4 even wrap");
    set_ptr(16'h42FF);
    dread("R4 odd no wrap");
    regs_chk("R4 odd no wrap");

    // R9: outside both regions
    set_mode(1'b0); set_ptr(16'(RAM_BASE + RAM_BYTES)); set_len(16'd5);
    dwrite(16'h0077);
    set_ptr(16'(RAM_BASE + RAM_BYTES));
    dread("R9 byte float");
    set_mode(1'b1); set_ptr(16'h0020);
    dread("R9 word float");
    set_mode(1'b0); set_ptr(16'(RAM_BASE));
    dread("R9 no alias write");

    // R11: soft reset restores PROM, clears flag, keeps registers
    set_ptr(16'h0000); set_len(16'd1);
    dwrite(16'h0099);
    set_ptr(16'h0000); set_len(16'd3);
    dread("R8 prom writable");
    bus(1'b0, 5'h1F, 0, q); chk("R11 read value", q, 16'h0000);
    prom_fill(); m_done = 1'b0;
    repeat (2) @(negedge clk);
    regs_chk("R11");
    set_ptr(16'h0000);
    dread("R11 prom restored");

    // seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 12);
      case (r)
        0: begin
          int k = int'($urandom % 8);
          if (k == 0) set_ptr(16'($urandom % 40));
          else if (k == 1) set_ptr(16'(RAM_BASE + RAM_BYTES + ($urandom % 8)));
          else set_ptr(16'(RAM_BASE + ($urandom % RAM_BYTES)));
        end
        1: set_len(($urandom % 5 == 0) ? 16'd0 : 16'($urandom % 40));
        2: set_mode(1'($urandom));
        3: begin
          logic [7:0] s = 8'(8'h40 + ($urandom % 15));
          set_ring(s, 8'(s + 1 + ($urandom % (8'h50 - s))));
        end
        4, 5, 6: dread("R2 R3 R7 random read");
        7, 8: dwrite(16'($urandom));
        9: regs_chk("R4 R5 random");
        10: begin
          setreg(5'h07, ($urandom % 2 == 0) ? 8'h40 : 8'h00);
          if (wdata[6]) m_done = 1'b0;
          chk("R10 random clear", {15'd0, done}, {15'd0, m_done});
        end
        default: begin
          bus(1'b0, 5'h07, 0, q);
          chk("R5 random status", q, {9'd0, m_done, 6'd0});
        end
      endcase
    end

    finish_run();
  end
endmodule